// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block runs 32-bit integer multiplication and division, signed or unsigned, one bit per clock cycle. Both operations share a single 64-bit working register and a single 33-bit adder. The caller pulses `start` with an operation code and two operands while the unit is idle. `busy` then stays high for the 32 iteration cycles and one closing cycle in which the signs are corrected. `done` pulses for one cycle when the new result appears on `hiOut`/`loOut`.

A multiply returns the full 64-bit product, with the upper word on `hiOut` and the lower word on `loOut`. A divide returns the remainder on `hiOut` and the quotient on `loOut`. Signed operations work on magnitudes and apply the signs in the closing cycle. A zero divisor raises no error. It gives a fixed, documented result in the normal cycle count.

Top module: `md_unit`

## Requirements
- R1: With opSel = 2'b01 (unsigned multiply), {hiOut, loOut} becomes the unsigned 64-bit product of opA and opB.
- R2: With opSel = 2'b00 (signed multiply), {hiOut, loOut} becomes the two's-complement 64-bit product of opA and opB.
- R3: With opSel = 2'b11 (unsigned divide) and opB nonzero, loOut becomes opA / opB and hiOut becomes opA mod opB, both unsigned.
- R4: With opSel = 2'b10 (signed divide) and opB nonzero, the quotient on loOut is truncated toward zero. The remainder on hiOut carries the sign of the dividend. The quotient is kept to 32 bits, so -2^31 / -1 gives 32'h80000000 with remainder 0.
- R5: If opB is zero in either divide, loOut becomes 32'hFFFFFFFF and hiOut becomes opA unchanged, with the normal latency.
- R6: `busy` rises at the clock edge that accepts `start` and stays high for exactly 33 cycles. `done` is high for exactly one cycle, starting at the edge where `busy` falls, and the new result is visible in that same cycle.
- R7: A `start` pulse while `busy` is high is ignored. It does not change the latency or the result of the operation in progress.
- R8: hiOut and loOut keep their values from one completion to the next. They do not change while an operation is in progress.
- R9: After reset, busy and done are 0 and hiOut and loOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only when idle |
| opSel | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opA | input | 32 | Multiplicand / dividend |
| opB | input | 32 | Multiplier / divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | 32 | Product upper word or remainder |
| loOut | output | 32 | Product lower word or quotient |

## Verification
The bench targets the sign corners of the unit:
- Negative-by-positive and most-negative-squared products expose a design that skips the 64-bit negation or lets the carry out of the adder drop from the product.
- Signed divisions with each operand negative in turn catch a remainder that follows the divisor's sign instead of the dividend's.
- -2^31 / -1 catches a quotient that is saturated instead of wrapped.
- Divide by zero, both signed and unsigned, catches a quotient that is wrongly negated or a remainder that is altered.
- A second `start` injected mid-run catches a controller that restarts or shortens the run, which would show as a wrong cycle count or a wrong result.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } mdCtl_t;
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import md_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output mdCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int CW = $clog2(ITERS);
  localparam int LW = $clog2(ITERS + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIX} state_e;

  state_e        state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == S_FIX);
      case (state)
        S_IDLE: if (start) begin
          state <= S_ITER;
          cnt   <= '0;
        end
        S_ITER: begin
          if (cnt == CW'(ITERS - 1)) state <= S_FIX;
          else cnt <= cnt + 1'b1;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == S_IDLE) && start;
    ctl.step = (state == S_ITER);
    ctl.fix  = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  // checker: length of the current busy run
  logic [LW-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fix |-> (busyLen == LW'(ITERS)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && start && cnt != CW'(ITERS - 1)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdCtl_t       ctl,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  localparam int AW = 2 * W;

  logic [AW-1:0] acc;
  logic [W-1:0]  mag;
  logic          isDiv, negProd, negQuo, negRem, divZero;

  // operand sign handling at load
  logic         signedOp, sA, sB;
  logic [W-1:0] absA, absB;
  always_comb begin
    signedOp = (opSel == OP_MUL) || (opSel == OP_DIV);
    sA   = signedOp && opA[W-1];
    sB   = signedOp && opB[W-1];
    absA = sA ? (~opA + 1'b1) : opA;
    absB = sB ? (~opB + 1'b1) : opB;
  end

  // the one shared adder: add for multiply, subtract for divide
  logic [W:0]   addL, addR;
  logic [W+1:0] sum;
  always_comb begin
    addL = isDiv ? acc[AW-1:W-1] : {1'b0, acc[AW-1:W]};
    addR = isDiv ? ~{1'b0, mag}  : {1'b0, mag};
    sum  = {1'b0, addL} + {1'b0, addR} + (W+2)'(isDiv);
  end

  logic [AW-1:0] prodFix;
  logic [W-1:0]  remFix, quoFix;
  always_comb begin
    prodFix = negProd ? (~acc + 1'b1) : acc;
    remFix  = negRem ? (~acc[AW-1:W] + 1'b1) : acc[AW-1:W];
    quoFix  = (negQuo && !divZero) ? (~acc[W-1:0] + 1'b1) : acc[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      mag     <= '0;
      isDiv   <= 1'b0;
      negProd <= 1'b0;
      negQuo  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
      hiOut   <= '0;
      loOut   <= '0;
    end else begin
      if (ctl.load) begin
        isDiv   <= opSel[1];
        negProd <= sA ^ sB;
        negQuo  <= sA ^ sB;
        negRem  <= sA;
        divZero <= (opB == '0);
        if (opSel[1]) begin
          acc <= {{W{1'b0}}, absA};
          mag <= absB;
        end else begin
          acc <= {{W{1'b0}}, absB};
          mag <= absA;
        end
      end else if (ctl.step) begin
        if (isDiv) begin
          if (sum[W+1]) acc <= {sum[W-1:0], acc[W-2:0], 1'b1};
          else          acc <= {acc[AW-2:0], 1'b0};
        end else begin
          if (acc[0]) acc <= {sum[W:0], acc[W-1:1]};
          else        acc <= {1'b0, acc[AW-1:1]};
        end
      end else if (ctl.fix) begin
        if (isDiv) begin
          hiOut <= remFix;
          loOut <= quoFix;
        end else begin
          hiOut <= prodFix[AW-1:W];
          loOut <= prodFix[W-1:0];
        end
      end
    end
  end

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && isDiv && mag != '0) |=> (acc[AW-1:W] < mag));

  // R5
  zero_div_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && isDiv && divZero) |=> acc[0]);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step || ctl.load) |=> ($stable(hiOut) && $stable(loOut)));
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  mdCtl_t ctl;

  md_ctrl #(.ITERS(W)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  md_datapath #(.W(W)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .opSel (opSel),
    .opA   (opA),
    .opB   (opB),
    .hiOut (hiOut),
    .loOut (loOut)
  );

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/test_md_unit.sv
module test_md_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  int checks = 0;
  int errors = 0;

  md_unit i_md_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refMul(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    if (op == 2'b01) return {32'h0, a} * {32'h0, b};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  function automatic logic [63:0] refDiv(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 32'h0) return {a, 32'hFFFF_FFFF};
    if (op == 2'b11) return {a % b, a / b};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  // one operation end to end; poke injects a stray start mid-run
  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string req, input bit poke);
    logic [63:0] exp, prev;
    int n;
    exp  = op[1] ? refDiv(op, a, b) : refMul(op, a, b);
    @(negedge clk);
    prev = {hiOut, loOut};
    start = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", 64'(busy), 64'd1);
    chk({hiOut, loOut} === prev, "R8 hold while busy", {hiOut, loOut}, prev);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start = 1'b1; opSel = op ^ 2'b01; opA = ~a; opB = b + 32'd3;
      end else begin
        start = 1'b0;
      end
    end
    chk(n == 33, poke ? "R7 latency with stray start" : "R6 latency", 64'(n), 64'd33);
    chk(busy === 1'b0, "R6 busy low at done", 64'(busy), 64'd0);
    chk({hiOut, loOut} === exp, req, {hiOut, loOut}, exp);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", 64'(done), 64'd0);
    chk({hiOut, loOut} === exp, "R8 hold after done", {hiOut, loOut}, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done} === 2'b00, "R9 reset flags", 64'({busy, done}), 64'd0);
    chk({hiOut, loOut} === 64'h0, "R9 reset result", {hiOut, loOut}, 64'h0);

    runOp(2'b01, 32'd7, 32'd6, "R1 multu small", 1'b0);
    runOp(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 multu max", 1'b0);
    runOp(2'b00, 32'hFFFF_FFFD, 32'd5, "R2 mult neg*pos", 1'b0);
    runOp(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 mult minneg squared", 1'b0);
    runOp(2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFF8, "R2 mult neg*neg", 1'b0);
    runOp(2'b11, 32'd100, 32'd7, "R3 divu basic", 1'b0);
    runOp(2'b11, 32'hFFFF_FFFF, 32'd1, "R3 divu by one", 1'b0);
    runOp(2'b11, 32'd5, 32'hFFFF_FFF0, "R3 divu small by large", 1'b0);
    runOp(2'b10, 32'hFFFF_FFF9, 32'd2, "R4 div neg dividend", 1'b0);
    runOp(2'b10, 32'd7, 32'hFFFF_FFFE, "R4 div neg divisor", 1'b0);
    runOp(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 div minneg by -1", 1'b0);
    runOp(2'b11, 32'd1234, 32'd0, "R5 divu by zero", 1'b0);
    runOp(2'b10, 32'hFFFF_FFFB, 32'd0, "R5 div signed by zero", 1'b0);
    runOp(2'b01, 32'd123456, 32'd789, "R7 multu with stray start", 1'b1);
    runOp(2'b10, 32'hFFFF_FC00, 32'd37, "R7 div with stray start", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule